// File: doc/BRIEF.md
# Program-Counter/Status Register File Read Path

This block is the general register file of a processor core with a 26-bit byte address space. Registers 0 to 14 are ordinary 32-bit storage. Register 15 is the program counter, and the processor status bits are packed into the same word around its address field. The block has one write port, a sequential program-counter increment, and three combinational read ports. The ports are the first operand, the second operand, and the shift-amount source.

A read of register 15 returns the program counter as the pipeline sees it: 8 bytes ahead, or 12 bytes ahead when the current instruction takes its shift amount from a register. The sum is masked to the word-aligned address field. The first-operand and shift-amount ports return this address with all status bits as zero. The shift-amount port always uses the 8-byte offset. The second-operand port returns the whole status word, built around the same offset address. Interrupt-entry strobes set the matching interrupt-disable bits. A flag-load input updates the four condition flags.

Top module: `pcpsr_regfile`

## Requirements
- R1: After reset the PC equals the parameter RESET_PC (bits 25:2). The flags and both interrupt-disable bits are zero, and the mode field (bits 1:0) reads 2'b11 (Supervisor).
- R2: With rn_sel_i = 15, rn_data_o = (PC + 8) & 32'h03FF_FFFC, or (PC + 12) & 32'h03FF_FFFC when shift_by_reg_i is 1. Bits 31:26 and 1:0 read as zero.
- R3: With rm_sel_i = 15, rm_data_o is the status word {N,Z,C,V,I,F, addr[25:2], mode}. N is bit 31, Z bit 30, C bit 29, V bit 28, I (IRQ disable) bit 27 and F (FIQ disable) bit 26. Its address field follows the same 8/12 offset rule as R2.
- R4: With rs_sel_i = 15, rs_data_o = (PC + 8) & 32'h03FF_FFFC whatever shift_by_reg_i is, with the status bits zero.
- R5: An offset sum that passes the top of the 26-bit space wraps: only bits 25:2 of the sum are kept.
- R6: pc_inc_i advances the PC by 4 at the clock edge, wrapping from 26'h3FF_FFFC to 0.
- R7: A write with wr_en_i = 1 and wr_sel_i in 0..14 is visible on every read port from the next cycle. A read of the same register in the write cycle returns the old value.
- R8: A write with wr_sel_i = 15 changes neither the PC, the status word nor registers 0..14.
- R9: flags_we_i loads flags_i[3:0] as {N,Z,C,V} into status bits 31:28. Z is stored as given; 1 marks a zero result.
- R10: irq_entry_i sets I and fiq_entry_i sets F. The bits stay set until reset, neither strobe clears the other bit, and strobes that arrive with a flag load or an increment in the same cycle all take effect.
- R11: Registers 0..14 read as zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rn_sel_i | input | 4 | First-operand register select |
| rm_sel_i | input | 4 | Second-operand register select |
| rs_sel_i | input | 4 | Shift-amount register select |
| shift_by_reg_i | input | 1 | Current instruction shifts by a register amount |
| rn_data_o | output | 32 | First-operand read data |
| rm_data_o | output | 32 | Second-operand read data |
| rs_data_o | output | 32 | Shift-amount read data |
| wr_en_i | input | 1 | Write enable |
| wr_sel_i | input | 4 | Write register select |
| wr_data_i | input | 32 | Write data |
| pc_inc_i | input | 1 | Advance the PC by one word |
| flags_we_i | input | 1 | Load the condition flags |
| flags_i | input | 4 | New {N,Z,C,V} |
| irq_entry_i | input | 1 | IRQ entry strobe |
| fiq_entry_i | input | 1 | FIQ entry strobe |

## Verification
Two pairs of functions can act in the same cycle. The first is a register write and a read of that same register. The bench drives a write to register 3 while rn_sel_i points at it. It expects the old contents in that cycle and the new contents on all three ports after the edge. The second is the state update: one cycle carries both interrupt strobes, a flag load and a PC increment. The bench then expects I and F both set, the new flags, and the address one word further on in the second-operand status word.

// File: rtl/pcpsr_pkg.sv
package pcpsr_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned NREG   = 16;
  localparam int unsigned SEL_W  = $clog2(NREG);
  localparam int unsigned ADDR_W = 24;  // word-address field width
  localparam int unsigned MODE_W = 2;
  localparam int unsigned HI_W   = XLEN - ADDR_W - MODE_W;

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 2'b00,
    MODE_FIQ = 2'b01,
    MODE_IRQ = 2'b10,
    MODE_SVC = 2'b11
  } cpu_mode_e;

  typedef enum logic [1:0] {
    PORT_OPND  = 2'd0,
    PORT_FULL  = 2'd1,
    PORT_SHAMT = 2'd2
  } rd_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
    logic i;
    logic f;
  } psr_hi_t;
endpackage

// File: rtl/pcpsr_gpr_bank.sv
module pcpsr_gpr_bank
  import pcpsr_pkg::*;
#(
  parameter int unsigned DATA_W = XLEN,
  parameter int unsigned NUM_REG = NREG,
  parameter int unsigned NUM_RD = 3,
  localparam int unsigned SW = $clog2(NUM_REG),
  localparam int unsigned NUM_GPR = NUM_REG - 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [SW-1:0]                wr_sel_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  input  logic [NUM_RD-1:0][SW-1:0]    rd_sel_i,
  output logic [NUM_RD-1:0][DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] gpr_q [NUM_REG];

  for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
    if (g < NUM_GPR) begin : g_store
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                 gpr_q[g] <= '0;
        else if (wr_en_i && wr_sel_i == SW'(g))      gpr_q[g] <= wr_data_i;
      end
    end else begin : g_pc_slot
      assign gpr_q[g] = '0;  // slot of the PC; served by the read ports
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rd_data_o[p] = gpr_q[rd_sel_i[p]];
  end

  AST_WR_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i != SW'(NUM_GPR)) |=> gpr_q[$past(wr_sel_i)] == $past(wr_data_i)); // R7
endmodule

// File: rtl/pcpsr_state.sv
module pcpsr_state
  import pcpsr_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pc_inc_i,
  input  logic          flags_we_i,
  input  logic [3:0]    flags_i,
  input  logic          irq_entry_i,
  input  logic          fiq_entry_i,
  output logic [AW-1:0] pc_addr_o,
  output psr_hi_t       hi_o,
  output cpu_mode_e     mode_o
);
  logic [AW-1:0] pc_q;
  psr_hi_t       hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pc_q <= RESET_PC[AW+1:2];
    else if (pc_inc_i) pc_q <= pc_q + AW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
    end else begin
      if (flags_we_i) {hi_q.n, hi_q.z, hi_q.c, hi_q.v} <= flags_i;
      if (irq_entry_i) hi_q.i <= 1'b1;
      if (fiq_entry_i) hi_q.f <= 1'b1;
    end
  end

  assign pc_addr_o = pc_q;
  assign hi_o      = hi_q;
  assign mode_o    = MODE_SVC;  // bank switching not modelled

  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_inc_i |=> pc_q == AW'($past(pc_q) + AW'(1))); // R6
  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_inc_i |=> $stable(pc_q)); // R8
  AST_IRQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_entry_i |=> hi_q.i); // R10
  AST_FIQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_entry_i |=> hi_q.f); // R10
  AST_MASK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_q.i || hi_q.f) |=> (hi_q.i >= $past(hi_q.i)) && (hi_q.f >= $past(hi_q.f))); // R10
endmodule

// File: rtl/pcpsr_rd_port.sv
module pcpsr_rd_port
  import pcpsr_pkg::*;
#(
  parameter rd_kind_e KIND = PORT_OPND,
  parameter int unsigned DATA_W = XLEN,
  parameter int unsigned AW = ADDR_W,
  localparam int unsigned PAD_HI = DATA_W - AW - MODE_W
) (
  input  logic              sel_is_pc_i,
  input  logic              shift_by_reg_i,
  input  logic [DATA_W-1:0] gpr_data_i,
  input  logic [AW-1:0]     pc_addr_i,
  input  psr_hi_t           hi_i,
  input  cpu_mode_e         mode_i,
  output logic [DATA_W-1:0] data_o
);
  logic          use_far;
  logic [AW-1:0] pc_fwd;
  logic [DATA_W-1:0] pc_word;

  // shift-amount port always sees +8; others see +12 under register shift
  assign use_far = (KIND != PORT_SHAMT) && shift_by_reg_i;
  assign pc_fwd  = pc_addr_i + (use_far ? AW'(3) : AW'(2));

  if (KIND == PORT_FULL) begin : g_full
    assign pc_word = {hi_i, pc_fwd, mode_i};
  end else begin : g_bare
    assign pc_word = {{PAD_HI{1'b0}}, pc_fwd, {MODE_W{1'b0}}};
  end

  assign data_o = sel_is_pc_i ? pc_word : gpr_data_i;
endmodule

// File: rtl/pcpsr_regfile.sv
module pcpsr_regfile
  import pcpsr_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [SEL_W-1:0] rn_sel_i,
  input  logic [SEL_W-1:0] rm_sel_i,
  input  logic [SEL_W-1:0] rs_sel_i,
  input  logic            shift_by_reg_i,
  output logic [XLEN-1:0] rn_data_o,
  output logic [XLEN-1:0] rm_data_o,
  output logic [XLEN-1:0] rs_data_o,
  input  logic            wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic            pc_inc_i,
  input  logic            flags_we_i,
  input  logic [3:0]      flags_i,
  input  logic            irq_entry_i,
  input  logic            fiq_entry_i
);
  localparam int unsigned NUM_RD = 3;
  localparam logic [SEL_W-1:0] PC_IDX = SEL_W'(NREG - 1);

  logic [NUM_RD-1:0][SEL_W-1:0] rd_sel;
  logic [NUM_RD-1:0][XLEN-1:0]  gpr_rd;
  logic [NUM_RD-1:0][XLEN-1:0]  port_rd;
  logic [ADDR_W-1:0] pc_addr;
  psr_hi_t           hi;
  cpu_mode_e         mode;

  assign rd_sel = {rs_sel_i, rm_sel_i, rn_sel_i};

  pcpsr_gpr_bank #(.DATA_W(XLEN), .NUM_REG(NREG), .NUM_RD(NUM_RD)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .rd_sel_i  (rd_sel),
    .rd_data_o (gpr_rd)
  );

  pcpsr_state #(.RESET_PC(RESET_PC), .AW(ADDR_W)) u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pc_inc_i    (pc_inc_i),
    .flags_we_i  (flags_we_i),
    .flags_i     (flags_i),
    .irq_entry_i (irq_entry_i),
    .fiq_entry_i (fiq_entry_i),
    .pc_addr_o   (pc_addr),
    .hi_o        (hi),
    .mode_o      (mode)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_port
    localparam rd_kind_e K = (p == 0) ? PORT_OPND : (p == 1) ? PORT_FULL : PORT_SHAMT;
    pcpsr_rd_port #(.KIND(K), .DATA_W(XLEN), .AW(ADDR_W)) u_port (
      .sel_is_pc_i    (rd_sel[p] == PC_IDX),
      .shift_by_reg_i (shift_by_reg_i),
      .gpr_data_i     (gpr_rd[p]),
      .pc_addr_i      (pc_addr),
      .hi_i           (hi),
      .mode_i         (mode),
      .data_o         (port_rd[p])
    );
  end

  assign rn_data_o = port_rd[0];
  assign rm_data_o = port_rd[1];
  assign rs_data_o = port_rd[2];

  AST_RS_FIXED_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rn_sel_i == PC_IDX && rs_sel_i == PC_IDX && !shift_by_reg_i) |-> rs_data_o == rn_data_o); // R4
  AST_RM_ADDR_AGREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rn_sel_i == PC_IDX && rm_sel_i == PC_IDX) |-> rm_data_o[25:2] == rn_data_o[25:2]); // R3
  AST_RN_STATUS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rn_sel_i == PC_IDX) |-> (rn_data_o[31:26] == '0 && rn_data_o[1:0] == '0)); // R2
endmodule

// File: tb/pcpsr_regfile_tb.sv
module pcpsr_regfile_tb;
  localparam logic [31:0] RST_PC = 32'h03FF_FFF0;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [3:0] rn_sel_i = '0, rm_sel_i = '0, rs_sel_i = '0, wr_sel_i = '0;
  logic shift_by_reg_i = 1'b0, wr_en_i = 1'b0, pc_inc_i = 1'b0;
  logic flags_we_i = 1'b0, irq_entry_i = 1'b0, fiq_entry_i = 1'b0;
  logic [3:0] flags_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rn_data_o, rm_data_o, rs_data_o;

  int n_chk = 0;
  int n_fail = 0;

  // bench model
  logic [25:0] pc_m;
  logic [3:0]  fl_m;
  logic        i_m, f_m;

  always #2 clk_i = ~clk_i;

  pcpsr_regfile #(.RESET_PC(RST_PC)) u_dut (.*);

  function automatic logic [31:0] pc_at(int unsigned off);
    return (32'(pc_m) + off) & 32'h03FF_FFFC;
  endfunction

  function automatic logic [31:0] psr_at(int unsigned off);
    return {fl_m, i_m, f_m, 26'b0} | pc_at(off) | 32'h3;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    wr_en_i = 0; pc_inc_i = 0; flags_we_i = 0; irq_entry_i = 0; fiq_entry_i = 0;
    step(); step();
    rst_ni = 1'b1;
    pc_m = RST_PC[25:0]; fl_m = '0; i_m = 0; f_m = 0;
    step();
  endtask

  task automatic t_reset();
    do_reset();
    rn_sel_i = 15; rm_sel_i = 15; rs_sel_i = 15; shift_by_reg_i = 0; #1;
    check("R1 status after reset", rm_data_o, 32'h03FF_FFFB);
    check("R2 rn pc+8", rn_data_o, 32'h03FF_FFF8);
    check("R4 rs pc+8", rs_data_o, 32'h03FF_FFF8);
    shift_by_reg_i = 1; #1;
    check("R2 rn pc+12", rn_data_o, 32'h03FF_FFFC);
    check("R3 rm pc+12", rm_data_o, 32'h03FF_FFFF);
    check("R4 rs ignores shift mode", rs_data_o, 32'h03FF_FFF8);
    rn_sel_i = 5; rm_sel_i = 0; rs_sel_i = 14; #1;
    check("R11 r5 zero", rn_data_o, 32'h0);
    check("R11 r0 zero", rm_data_o, 32'h0);
    check("R11 r14 zero", rs_data_o, 32'h0);
    shift_by_reg_i = 0;
  endtask

  task automatic t_wrap();
    do_reset();
    rn_sel_i = 15; rm_sel_i = 15; rs_sel_i = 15;
    pc_inc_i = 1; step(); pc_inc_i = 0; pc_m = pc_m + 26'd4;
    shift_by_reg_i = 1; #1;
    check("R5 rn wraps", rn_data_o, 32'h0);
    check("R5 rm wraps", rm_data_o, 32'h3);
    check("R5 rs no wrap yet", rs_data_o, 32'h03FF_FFFC);
    shift_by_reg_i = 0;
    for (int k = 0; k < 3; k++) begin
      pc_inc_i = 1; step(); pc_m = pc_m + 26'd4;
    end
    pc_inc_i = 0; #1;
    check("R6 pc wrapped to 0", rs_data_o, 32'h8);
    check("R6 model agrees", rm_data_o, psr_at(8));
  endtask

  task automatic t_write();
    do_reset();
    rn_sel_i = 3;
    wr_en_i = 1; wr_sel_i = 3; wr_data_i = 32'hA5C3_0F18; #1;
    check("R7 old value in write cycle", rn_data_o, 32'h0);
    step();
    wr_sel_i = 14; wr_data_i = 32'h1234_5678; step(); wr_en_i = 0;
    rm_sel_i = 3; rs_sel_i = 3; #1;
    check("R7 rn new", rn_data_o, 32'hA5C3_0F18);
    check("R7 rm new", rm_data_o, 32'hA5C3_0F18);
    check("R7 rs new", rs_data_o, 32'hA5C3_0F18);
    rn_sel_i = 14; #1;
    check("R7 r14", rn_data_o, 32'h1234_5678);
  endtask

  task automatic t_pc_write();
    // follows t_write: r3 and r14 hold data
    wr_en_i = 1; wr_sel_i = 15; wr_data_i = 32'hFFFF_FFFF; step(); wr_en_i = 0;
    rn_sel_i = 3; rm_sel_i = 15; rs_sel_i = 14; #1;
    check("R8 status unchanged", rm_data_o, psr_at(8));
    check("R8 r3 unchanged", rn_data_o, 32'hA5C3_0F18);
    check("R8 r14 unchanged", rs_data_o, 32'h1234_5678);
  endtask

  task automatic t_flags();
    do_reset();
    flags_we_i = 1; flags_i = 4'b1010; step(); flags_we_i = 0; fl_m = 4'b1010;
    rn_sel_i = 15; rm_sel_i = 15; #1;
    check("R9 flags in status", rm_data_o, psr_at(8));
    check("R9 N,C bits", rm_data_o[31:28], 4'b1010);
    check("R2 rn hides flags", rn_data_o, pc_at(8));
    flags_we_i = 1; flags_i = 4'b0101; step(); flags_we_i = 0; fl_m = 4'b0101; #1;
    check("R9 Z,V bits", rm_data_o, psr_at(8));
  endtask

  task automatic t_irq();
    do_reset();
    rm_sel_i = 15;
    irq_entry_i = 1; step(); irq_entry_i = 0; i_m = 1; #1;
    check("R10 irq sets I only", rm_data_o[27:26], 2'b10);
    fiq_entry_i = 1; step(); fiq_entry_i = 0; f_m = 1; #1;
    check("R10 fiq keeps I", rm_data_o[27:26], 2'b11);
    flags_we_i = 1; flags_i = 4'b0000; irq_entry_i = 1; step();
    flags_we_i = 0; irq_entry_i = 0; #1;
    check("R10 bits sticky", rm_data_o, psr_at(8));
    // all state updates in one cycle
    do_reset();
    irq_entry_i = 1; fiq_entry_i = 1; flags_we_i = 1; flags_i = 4'b0110; pc_inc_i = 1;
    step();
    irq_entry_i = 0; fiq_entry_i = 0; flags_we_i = 0; pc_inc_i = 0;
    i_m = 1; f_m = 1; fl_m = 4'b0110; pc_m = pc_m + 26'd4; #1;
    check("R10 concurrent update", rm_data_o, psr_at(8));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_wrap();
    t_write();
    t_pc_write();
    t_flags();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule